// File: doc/BRIEF.md
# Vertical Sync Regenerator with Field Detection

This block sits in the pixel clock domain behind a sync separator. It receives clean, active-high horizontal and vertical sync pulses. It times each line in pixel clocks and finds where every vertical sync leading edge lands within the line. From that position it decides whether the frame is field 0 or field 1. One line later it emits a new vertical sync pulse with a known phase to the horizontal sync: at a line start for field 0, or at mid-line for field 1.

Edges that come too soon after the previous accepted one are dropped as glitches. The output pulse can either follow the input pulse length or be forced to a programmed number of lines. A line counter reports how many horizontal sync edges occurred between accepted vertical syncs. When filtering is switched off, the input vertical sync is passed straight through.

Top module: `vsync_field_filter`

## Requirements
- R1: After reset, vsync_o is at its inactive level, field_o is 0 and lines_o is 0.
- R2: Let pos be the pixel clocks since the latest hsync_i rising edge (0 in the edge cycle), P the last measured line period and T = sep_thresh_i. The offset is pos-T when pos >= T, otherwise pos+P-T. With q = P>>2, an offset below q or at least 3q selects field 0, and an offset in [q, 3q) selects field 1.
- R3: For field 0, the regenerated pulse starts in the cycle of the first hsync_i rising edge after the line in which the edge was accepted. vsync_o and field_o update one clock after that cycle.
- R4: For field 1, the regenerated pulse starts in the following line at pos == P>>1. vsync_o and field_o update one clock later.
- R5: A vsync_i rising edge is accepted only if at least 64 hsync_i rising edges have come after the previous accepted edge. An hsync edge in the same cycle as an acceptance is not counted. Rejected edges change neither the outputs nor lines_o.
- R6: With dur_en_i = 1, the pulse lasts exactly dur_lines_i lines, and a value of 0 acts as 1. The pulse ends at the matching line position (line start or mid-line) that many lines after it began.
- R7: With dur_en_i = 0, the pulse ends at the first later line position of the same kind as its start at which vsync_i is sampled low.
- R8: With filt_en_i = 0, vsync_o follows vsync_i one clock late, with no spacing check, and field_o is 0 whatever the polarity setting.
- R9: At each accepted edge, lines_o loads the number of hsync_i rising edges counted since the previous accepted edge. An hsync edge in the same cycle as the acceptance counts toward the next frame.
- R10: The hsync-per-vsync count saturates at 4095.
- R11: vs_pol_i = 1 makes vsync_o active high and 0 makes it active low. fld_pol_i = 1 drives field_o high for field 1, and 0 drives it high for field 0.
- R12: Until two hsync_i rising edges have been seen after reset, no vsync_i edge is accepted and no regenerated pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| sep_thresh_i | input | POS_W | Sync separator threshold in pixel clocks |
| filt_en_i | input | 1 | Enable filtering and regeneration |
| dur_en_i | input | 1 | Use programmed pulse length |
| dur_lines_i | input | DUR_W | Programmed pulse length in lines |
| vs_pol_i | input | 1 | vsync_o polarity (1 = active high) |
| fld_pol_i | input | 1 | field_o polarity |
| vsync_o | output | 1 | Regenerated or bypassed vertical sync |
| field_o | output | 1 | Field indicator |
| lines_o | output | CNT_W | Latched hsync count per accepted vsync |

## Verification
A vsync_i rising edge can land in the same clock as an hsync_i rising edge. In that one cycle the classifier, the spacing counter and the line counter all act at once. The bench provokes this twice. The first time, an accepted edge falls exactly on a line start: the bench expects field 0 (the wrapped offset falls in quadrant 4), a pulse starting one full line later rather than at once, and a next lines_o that includes the coincident edge. The second time, an edge is placed on the line start where the spacing count would reach 64, and the bench expects it to be rejected because the coincident hsync edge has not yet been counted.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  typedef enum logic [1:0] {
    QD_FIRST  = 2'd0,
    QD_SECOND = 2'd1,
    QD_THIRD  = 2'd2,
    QD_FOURTH = 2'd3
  } quad_e;
endpackage

// File: rtl/vsf_line_timer.sv
module vsf_line_timer #(
  parameter int POS_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  output logic             hs_rise_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] period_o,
  output logic             period_ok_o
);
  logic             hs_q, seen_q, ok_q;
  logic [POS_W-1:0] pos_q, per_q;

  assign hs_rise_o   = hsync_i & ~hs_q;
  assign period_o    = per_q;
  assign period_ok_o = ok_q;

  always_comb begin
    if (hs_rise_o)         pos_o = '0;
    else if (pos_q == '1)  pos_o = pos_q;
    else                   pos_o = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      seen_q <= 1'b0;
      ok_q   <= 1'b0;
      pos_q  <= '0;
      per_q  <= '0;
    end else begin
      hs_q  <= hsync_i;
      pos_q <= pos_o;
      if (hs_rise_o) begin
        seen_q <= 1'b1;
        if (seen_q) begin
          per_q <= pos_q + 1'b1;
          ok_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vsf_quadrant.sv
module vsf_quadrant
  import vsf_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] period_i,
  input  logic [POS_W-1:0] thresh_i,
  output quad_e            quad_o
);
  localparam int W = POS_W + 2;

  logic [W-1:0] pos_w, per_w, thr_w, off, qtr;

  always_comb begin
    pos_w = W'(pos_i);
    per_w = W'(period_i);
    thr_w = W'(thresh_i);
    qtr   = per_w >> 2;
    off   = (pos_w >= thr_w) ? (pos_w - thr_w) : (pos_w + per_w - thr_w);
    if (off < qtr)              quad_o = QD_FIRST;
    else if (off < (qtr << 1))  quad_o = QD_SECOND;
    else if (off < (qtr * 3))   quad_o = QD_THIRD;
    else                        quad_o = QD_FOURTH;
  end
endmodule

// File: rtl/vsf_gate.sv
module vsf_gate #(
  parameter int CNT_W     = 12,
  parameter int GAP_LINES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_rise_i,
  input  logic             vsync_i,
  input  logic             period_ok_i,
  output logic             accept_o,
  output logic             vs_d_o,
  output logic [CNT_W-1:0] lines_o
);
  localparam int GAP_W = $clog2(GAP_LINES + 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(GAP_LINES);

  logic             vs_q;
  logic [GAP_W-1:0] spc_q;
  logic [CNT_W-1:0] hs_cnt_q, lines_q;

  assign vs_d_o   = vs_q;
  assign lines_o  = lines_q;
  assign accept_o = vsync_i & ~vs_q & period_ok_i & (spc_q == GAP_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q     <= 1'b0;
      spc_q    <= GAP_FULL;
      hs_cnt_q <= '0;
      lines_q  <= '0;
    end else begin
      vs_q <= vsync_i;
      if (accept_o) begin
        spc_q    <= '0;
        hs_cnt_q <= hs_rise_i ? CNT_W'(1) : '0;
        lines_q  <= hs_cnt_q;
      end else if (hs_rise_i) begin
        if (spc_q != GAP_FULL) spc_q <= spc_q + 1'b1;
        if (hs_cnt_q != '1)    hs_cnt_q <= hs_cnt_q + 1'b1;
      end
    end
  end

  assert_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
  assert_sat_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_cnt_q == '1 && !accept_o) |=> hs_cnt_q == '1);
  assert_lines_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |=> $stable(lines_o));
endmodule

// File: rtl/vsf_regen.sv
module vsf_regen #(
  parameter int POS_W = 12,
  parameter int DUR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_rise_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] period_i,
  input  logic             accept_i,
  input  logic             odd_i,
  input  logic             vsync_i,
  input  logic             dur_en_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             act_o,
  output logic             field_o
);
  logic             pend_q, pend_odd_q, arm_q, act_q, field_q;
  logic [DUR_W-1:0] rem_q;
  logic             mid_hit, evt_cur, start, stop;

  assign mid_hit = !hs_rise_i && (pos_i == (period_i >> 1));
  assign evt_cur = field_q ? mid_hit : hs_rise_i;
  assign start   = (pend_q && !pend_odd_q && hs_rise_i) || (arm_q && mid_hit);
  assign stop    = act_q && !start && evt_cur &&
                   (dur_en_i ? (rem_q <= DUR_W'(1)) : !vsync_i);
  assign act_o   = act_q;
  assign field_o = field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_odd_q <= 1'b0;
      arm_q      <= 1'b0;
      act_q      <= 1'b0;
      field_q    <= 1'b0;
      rem_q      <= '0;
    end else begin
      // pend: waiting for next line; arm: field 1 waiting for mid-line
      if (accept_i) begin
        pend_q     <= 1'b1;
        pend_odd_q <= odd_i;
        arm_q      <= 1'b0;
      end else if (pend_q && hs_rise_i) begin
        pend_q <= 1'b0;
        arm_q  <= pend_odd_q;
      end else if (arm_q && mid_hit) begin
        arm_q <= 1'b0;
      end

      if (start) begin
        act_q   <= 1'b1;
        field_q <= pend_odd_q;
        rem_q   <= dur_i;
      end else if (stop) begin
        act_q <= 1'b0;
      end else if (act_q && evt_cur && dur_en_i) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assert_end_on_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> $past(evt_cur));
  assert_field_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !start) |=> $stable(field_q));
endmodule

// File: rtl/vsync_field_filter.sv
module vsync_field_filter
  import vsf_pkg::*;
#(
  parameter int POS_W     = 12,
  parameter int CNT_W     = 12,
  parameter int DUR_W     = 8,
  parameter int GAP_LINES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic [POS_W-1:0] sep_thresh_i,
  input  logic             filt_en_i,
  input  logic             dur_en_i,
  input  logic [DUR_W-1:0] dur_lines_i,
  input  logic             vs_pol_i,
  input  logic             fld_pol_i,
  output logic             vsync_o,
  output logic             field_o,
  output logic [CNT_W-1:0] lines_o
);
  logic             hs_rise, per_ok, accept, vs_d, act, fld, odd;
  logic [POS_W-1:0] pos, period;
  quad_e            quad;

  vsf_line_timer #(.POS_W(POS_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i),
    .hs_rise_o(hs_rise), .pos_o(pos), .period_o(period), .period_ok_o(per_ok)
  );

  vsf_quadrant #(.POS_W(POS_W)) u_quad (
    .pos_i(pos), .period_i(period), .thresh_i(sep_thresh_i), .quad_o(quad)
  );

  assign odd = (quad == QD_SECOND) || (quad == QD_THIRD);

  vsf_gate #(.CNT_W(CNT_W), .GAP_LINES(GAP_LINES)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_rise_i(hs_rise), .vsync_i(vsync_i),
    .period_ok_i(per_ok), .accept_o(accept), .vs_d_o(vs_d), .lines_o(lines_o)
  );

  vsf_regen #(.POS_W(POS_W), .DUR_W(DUR_W)) u_regen (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_rise_i(hs_rise), .pos_i(pos),
    .period_i(period), .accept_i(accept), .odd_i(odd), .vsync_i(vsync_i),
    .dur_en_i(dur_en_i), .dur_i(dur_lines_i), .act_o(act), .field_o(fld)
  );

  assign vsync_o = (filt_en_i ? act : vs_d) ^ ~vs_pol_i;
  assign field_o = filt_en_i & (fld ~^ fld_pol_i);

  assert_no_accept_unmeasured_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_ok |-> !accept);
  assert_no_pulse_unmeasured_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_ok |-> !act);
endmodule

// File: tb/vsync_field_filter_tb.sv
`timescale 1ns/1ps
module vsync_field_filter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsync_i = 1'b0, vsync_i = 1'b0;
  logic [11:0] sep_thresh_i = 12'd2;
  logic        filt_en_i = 1'b1, dur_en_i = 1'b0;
  logic [7:0]  dur_lines_i = 8'd4;
  logic        vs_pol_i = 1'b1, fld_pol_i = 1'b1;
  logic        vsync_o, field_o;
  logic [11:0] lines_o;

  int cyc = 0, base = 1 << 30, vs_on = -1, vs_off = -1;
  int rise_at = -1, fall_at = -1, n_rise = 0;
  int n_chk = 0, n_bad = 0;
  logic prev_o = 1'b0;
  bit done = 0;

  vsync_field_filter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .sep_thresh_i(sep_thresh_i), .filt_en_i(filt_en_i), .dur_en_i(dur_en_i),
    .dur_lines_i(dur_lines_i), .vs_pol_i(vs_pol_i), .fld_pol_i(fld_pol_i),
    .vsync_o(vsync_o), .field_o(field_o), .lines_o(lines_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor first, then drive the inputs for posedge number cyc
  always @(negedge clk) begin
    if (vsync_o !== prev_o) begin
      if (vsync_o == vs_pol_i) begin rise_at = cyc - 1; n_rise++; end
      else fall_at = cyc - 1;
      prev_o = vsync_o;
    end
    rst_ni  = (cyc >= 5);
    hsync_i = (cyc < base) ? ((cyc % 40) < 4) : (((cyc - base) % 8) < 4);
    vsync_i = (cyc >= vs_on) && (cyc < vs_off);
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_until(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic pulse(input int on, input int len);
    vs_on = on; vs_off = on + len;
  endtask

  task automatic regen_case(input string req, input int on, input int len,
                            input int e_rise, input int e_fall, input int e_fld, input int e_lines);
    rise_at = -1; fall_at = -1;
    pulse(on, len);
    wait_until(((e_fall > on + len) ? e_fall : on + len) + 5);
    check({req, " rise"}, rise_at, e_rise);
    check({req, " fall"}, fall_at, e_fall);
    check({req, " field"}, int'(field_o), e_fld);
    check({req, " lines"}, int'(lines_o), e_lines);
  endtask

  task automatic t_reset;
    wait_until(8);
    check("R1 vsync idle", int'(vsync_o), 0);
    check("R1 field", int'(field_o), 0);
    check("R1 lines", int'(lines_o), 0);
  endtask

  task automatic t_unmeasured;
    pulse(50, 10);
    wait_until(110);
    check("R12 no pulse before period known", n_rise, 0);
    check("R12 no latch", int'(lines_o), 0);
  endtask

  task automatic t_field0_passwidth;
    dur_en_i = 1'b0;
    regen_case("R3 R7 R2 field0 q1", 125, 120, 160, 280, 0, 3);
  endtask

  task automatic t_too_close;
    int r0 = n_rise;
    pulse(1605, 120);
    wait_until(1605 + 200);
    check("R5 close edge rejected", n_rise, r0);
    check("R5 lines unchanged", int'(lines_o), 3);
  endtask

  task automatic t_field1_duration;
    dur_en_i = 1'b1; dur_lines_i = 8'd2;
    regen_case("R4 R6 field1 q3", 2825, 120, 2860, 2940, 1, 67);
  endtask

  task automatic t_quadrant_edges;
    dur_lines_i = 8'd1;
    regen_case("R2 q4 wrap", 5601, 20, 5640, 5680, 0, 70);
    dur_en_i = 1'b0;
    regen_case("R2 R7 q2 lower edge", 8412, 120, 8460, 8540, 1, 70);
    dur_en_i = 1'b1; dur_lines_i = 8'd3;
    regen_case("R2 R6 q4 lower edge", 11232, 20, 11240, 11360, 0, 70);
  endtask

  task automatic t_coincident;
    dur_lines_i = 8'd1;
    regen_case("R9 R3 edge on hsync", 14000, 20, 14040, 14080, 0, 69);
    dur_lines_i = 8'd0;
    regen_case("R9 R6 coincident counted next", 16805, 20, 16840, 16880, 0, 71);
  endtask

  task automatic t_gap_boundary;
    int r0 = n_rise;
    dur_lines_i = 8'd1;
    pulse(19360, 10);
    wait_until(19420);
    check("R5 edge at 63 lines rejected", n_rise, r0);
    check("R5 lines kept", int'(lines_o), 71);
    regen_case("R5 accepted after 64", 19445, 20, 19480, 19520, 0, 66);
  endtask

  task automatic t_saturate;
    base = 19560;
    pulse(53165, 3);
    wait_until(53250);
    check("R10 count saturates", int'(lines_o), 4095);
  endtask

  task automatic t_polarity;
    int f1 = int'(field_o);
    vs_pol_i = 1'b0; fld_pol_i = 1'b0;
    #1;
    check("R11 active-low idle", int'(vsync_o), 1);
    check("R11 field inverted", int'(field_o), 1 - f1);
    vs_pol_i = 1'b1; fld_pol_i = 1'b1;
    #1;
    check("R11 active-high idle", int'(vsync_o), 0);
  endtask

  task automatic t_bypass;
    int on;
    fld_pol_i = 1'b0;
    filt_en_i = 1'b0;
    @(negedge clk);
    check("R8 field forced low", int'(field_o), 0);
    on = cyc + 5;
    rise_at = -1; fall_at = -1;
    pulse(on, 3);
    wait_until(on + 10);
    check("R8 passthrough rise", rise_at, on);
    check("R8 passthrough fall", fall_at, on + 3);
  endtask

  initial begin
    t_reset();
    t_unmeasured();
    t_field0_passwidth();
    t_too_close();
    t_field1_duration();
    t_quadrant_edges();
    t_coincident();
    t_gap_boundary();
    t_saturate();
    t_polarity();
    t_bypass();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule